// File: doc/BRIEF.md
# Periodic Reload Tick Timer

A 24-bit down-counter that produces a steady system tick for a processor. Software loads a period value, starts the counter and receives a one-cycle interrupt pulse each time the count runs out; the counter then refills itself from the period value and carries on. The tick source is either the core clock itself or an external slow reference strobe. That strobe is synchronised into the core domain, and only its rising edges are counted.

A sticky wrap flag records that at least one period completed since software last looked. It is cleared by reading the control word, or by a write to the live count. A separate 32-bit cycle total keeps a running account of elapsed ticks across periods. Software can therefore build a long timebase without handling every interrupt.

Access is a simple single-cycle register port. Read data is combinational in the cycle of the request, and writes take effect at the clock edge that ends the request cycle.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, all four registers (control at word 0, period at word 1, live count at word 2, cycle total at word 3) read zero and the interrupt output is low.
- R2: With run enable set (control bit 0) and source select set (control bit 2), the live count falls by one on every core clock. A period value of N gives one wrap every N+1 ticks.
- R3: A tick that finds the live count at zero loads the period value, including the full-scale value 0xFFFFFF. A write to the period register does not disturb the live count.
- R4: The tick that takes the live count from one to zero sets the wrap flag, which reads at control bit 16. A read of the control word returns the flag and clears it. A wrap in the same cycle as that read leaves the flag set.
- R5: The wrap tick raises the interrupt output for exactly one cycle, in the cycle after that tick, and only while interrupt enable (control bit 1) is set.
- R6: A write of any data to the live-count register forces the count to zero and clears the wrap flag. A tick in the same cycle is discarded.
- R7: Clearing run enable freezes the live count at its present value. Setting it again resumes counting from that value.
- R8: With source select clear, the count moves once for each rising edge of the reference strobe. The step lands on the third core clock edge that samples the strobe high, and a strobe held high counts only once.
- R9: Each tick that finds the live count at zero adds the period value plus one to an internal sum. The cycle-total register reads that sum plus the period value minus the live count, modulo 2^32.
- R10: A period value of zero holds the live count at zero, and the wrap flag and interrupt are never raised.
- R11: Unused control bits and period bits 31:24 read as zero. Writes to those bits, and writes to the cycle-total register, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| ref_tick_in | input | 1 | Asynchronous reference strobe |
| tick_irq | output | 1 | One-cycle wrap interrupt pulse |

## Verification
A live count that slips by one tick shows up within one period as an interrupt pulse in the wrong cycle. The per-clock comparison of the interrupt line reports it there, long before any register read would. A wrap flag or sum that goes wrong stays hidden until software reads it back. For that reason the bench reads the control word and the cycle total right after wraps, after forced clears and after reload changes. A fault in the strobe path shows up as a live count that is off by one at the next read, when the bench runs in reference-strobe mode.

// File: rtl/tt_pkg.sv
// Shared constants for the tick timer: register word map and control bit
// positions. Assumes a 32-bit register port with word addressing.
package tt_pkg;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int STAT_WRAP_BIT = 16;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_PERIOD  = 2'd1,
        REG_LIVE    = 2'd2,
        REG_TOTAL   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tt_ref_sync.sv
// Reference strobe synchroniser and rising-edge detector.
// Assumes ref_in is asynchronous and slower than clk. Produces a one-cycle
// pulse per rising edge, STAGES cycles after capture.
module tt_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic edge_pulse
);
    localparam int LAST = STAGES;

    logic [LAST:0] shift_q;

    // First capture flop of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q[0] <= 1'b0;
        else        shift_q[0] <= ref_in;
    end

    genvar g;
    generate
        for (g = 1; g <= LAST; g++) begin : g_stage
            // Further synchroniser / history stage.
            always_ff @(posedge clk) begin
                if (!rst_n) shift_q[g] <= 1'b0;
                else        shift_q[g] <= shift_q[g-1];
            end
        end
    endgenerate

    assign edge_pulse = shift_q[LAST-1] & ~shift_q[LAST];

    p_pulse_isolated_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/tt_core.sv
// Counting engine: live count, wrap flag, interrupt pulse and cycle sum.
// Assumes tick, clear_live and rd_status are single-cycle qualifiers from
// the register block; clear_live has priority over tick.
module tt_core #(
    parameter int CNT_W = 24,
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear_live,
    input  logic             rd_status,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] live,
    output logic             wrap_flag,
    output logic             irq,
    output logic [TOT_W-1:0] total
);
    localparam int PAD_W = TOT_W - CNT_W;

    logic [CNT_W-1:0] live_q;
    logic             flag_q;
    logic             irq_q;
    logic [TOT_W-1:0] sum_q;
    logic             at_zero;
    logic             at_one;
    logic             wrap_evt;
    logic             refill_evt;
    logic [TOT_W-1:0] period_ext;
    logic [TOT_W-1:0] live_ext;

    assign at_zero    = (live_q == '0);
    assign at_one     = (live_q == CNT_W'(1));
    assign wrap_evt   = tick && at_one && !clear_live;
    assign refill_evt = tick && at_zero && !clear_live;
    assign period_ext = {{PAD_W{1'b0}}, period};
    assign live_ext   = {{PAD_W{1'b0}}, live_q};

    // Live count: forced clear, refill at zero, otherwise step down.
    always_ff @(posedge clk) begin
        if (!rst_n)          live_q <= '0;
        else if (clear_live) live_q <= '0;
        else if (tick) begin
            if (at_zero) live_q <= period;
            else         live_q <= live_q - CNT_W'(1);
        end
    end

    // Sticky wrap flag: a wrap wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag_q <= 1'b0;
        else if (wrap_evt)                flag_q <= 1'b1;
        else if (clear_live || rd_status) flag_q <= 1'b0;
    end

    // One-cycle interrupt pulse per wrap when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= wrap_evt && irq_en;
    end

    // Running sum of whole periods, advanced at each refill.
    always_ff @(posedge clk) begin
        if (!rst_n)          sum_q <= '0;
        else if (refill_evt) sum_q <= sum_q + period_ext + TOT_W'(1);
    end

    assign live      = live_q;
    assign wrap_flag = flag_q;
    assign irq       = irq_q;
    assign total     = sum_q + period_ext - live_ext;

    p_irq_isolated_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_with_flag_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wrap_flag);
    p_refill_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && live == '0 && !clear_live) |=> (live == $past(period)));
    p_step_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && live != '0 && !clear_live) |=> (live == $past(live) - CNT_W'(1)));
    p_clear_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        clear_live |=> (live == '0 && !wrap_flag));
    p_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear_live) |=> $stable(live));
    p_zero_quiet_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0 && live == '0) |=> !irq);
    p_sum_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        !refill_evt |=> $stable(sum_q));
endmodule

// File: rtl/tt_regs.sv
// Register block: control bits, period register, access decode, read mux.
// Assumes a single-cycle request; read data is combinational in that cycle.
module tt_regs
    import tt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int TOT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  live,
    input  logic              wrap_flag,
    input  logic [TOT_W-1:0]  total,
    output logic              run_en,
    output logic              irq_en,
    output logic              core_src,
    output logic [CNT_W-1:0]  period,
    output logic              clear_live,
    output logic              rd_status
);
    reg_sel_e sel;
    logic     wr_ctrl;
    logic     wr_period;
    logic     en_q, ie_q, src_q;
    logic [CNT_W-1:0] period_q;

    assign sel        = reg_sel_e'(addr);
    assign wr_ctrl    = req && we && (sel == REG_CTRL);
    assign wr_period  = req && we && (sel == REG_PERIOD);
    assign clear_live = req && we && (sel == REG_LIVE);
    assign rd_status  = req && !we && (sel == REG_CTRL);

    // Control bits: run enable, interrupt enable, source select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ie_q  <= 1'b0;
            src_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q  <= wdata[CTRL_EN_BIT];
            ie_q  <= wdata[CTRL_IE_BIT];
            src_q <= wdata[CTRL_SRC_BIT];
        end
    end

    // Period register keeps only the counter-width bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         period_q <= '0;
        else if (wr_period) period_q <= wdata[CNT_W-1:0];
    end

    // Read mux with zero fill of unused bits.
    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_CTRL: begin
                rdata[CTRL_EN_BIT]   = en_q;
                rdata[CTRL_IE_BIT]   = ie_q;
                rdata[CTRL_SRC_BIT]  = src_q;
                rdata[STAT_WRAP_BIT] = wrap_flag;
            end
            REG_PERIOD: rdata = DATA_W'(period_q);
            REG_LIVE:   rdata = DATA_W'(live);
            REG_TOTAL:  rdata = DATA_W'(total);
        endcase
    end

    assign run_en   = en_q;
    assign irq_en   = ie_q;
    assign core_src = src_q;
    assign period   = period_q;

    p_period_write_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_period |=> (period == $past(wdata[CNT_W-1:0])));
    p_ctrl_keep_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(run_en));
endmodule

// File: rtl/tick_timer.sv
// Top level of the periodic reload tick timer. Joins the register block,
// the reference-strobe synchroniser and the counting engine, and picks the
// tick source. Assumes one clock domain apart from ref_tick_in.
module tick_timer #(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 24,
    parameter int TOT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick_in,
    output logic              tick_irq
);
    logic             run_en, irq_en, core_src;
    logic             clear_live, rd_status;
    logic [CNT_W-1:0] period, live;
    logic             wrap_flag;
    logic [TOT_W-1:0] total;
    logic             ref_pulse;
    logic             tick;

    tt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req(bus_req), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .live(live), .wrap_flag(wrap_flag), .total(total),
        .run_en(run_en), .irq_en(irq_en), .core_src(core_src),
        .period(period), .clear_live(clear_live), .rd_status(rd_status)
    );

    tt_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_tick_in), .edge_pulse(ref_pulse)
    );

    assign tick = run_en && (core_src || ref_pulse);

    tt_core #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .tick(tick), .clear_live(clear_live), .rd_status(rd_status),
        .irq_en(irq_en), .period(period),
        .live(live), .wrap_flag(wrap_flag), .irq(tick_irq), .total(total)
    );

    p_no_tick_when_stopped_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clear_live) |=> $stable(live));
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        ref_tick_in = 1'b0;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_tick_in(ref_tick_in), .tick_irq(tick_irq)
    );

    always #10 clk = ~clk;

    // Behavioural reference model, advanced once per rising edge.
    bit          m_en, m_ie, m_src, m_flag, m_irq;
    int unsigned m_period, m_live, m_sum;
    bit          m_h0, m_h1, m_h2;

    always @(posedge clk) begin
        bit strobe_edge, step, forced, status_read, wrapped;
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
            m_period = 0; m_live = 0; m_sum = 0;
            m_h0 = 0; m_h1 = 0; m_h2 = 0;
        end else begin
            strobe_edge = m_h1 && !m_h2;
            step        = m_en && (m_src || strobe_edge);
            forced      = bus_req && bus_we && bus_addr == 2'd2;
            status_read = bus_req && !bus_we && bus_addr == 2'd0;
            wrapped     = 0;
            if (forced) m_live = 0;
            else if (step) begin
                if (m_live == 0) begin
                    m_live = m_period;
                    m_sum  = m_sum + m_period + 1;
                end else begin
                    if (m_live == 1) wrapped = 1;
                    m_live = m_live - 1;
                end
            end
            m_irq = wrapped && m_ie;
            if (wrapped) m_flag = 1;
            else if (forced || status_read) m_flag = 0;
            if (bus_req && bus_we && bus_addr == 2'd0) begin
                m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
            end
            if (bus_req && bus_we && bus_addr == 2'd1) m_period = bus_wdata & 32'h00FF_FFFF;
            m_h2 = m_h1; m_h1 = m_h0; m_h0 = ref_tick_in;
        end
    end

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {15'd0, m_flag, 13'd0, m_src, m_ie, m_en};
            2'd1:    return m_period;
            2'd2:    return m_live;
            default: return m_sum + m_period - m_live;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R5: interrupt line compared against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) chk("R5 irq pulse", {31'd0, tick_irq}, {31'd0, m_irq});
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        #5 chk(tag, bus_rdata, model_read(a));
        @(negedge clk);
        bus_req = 0;
    endtask

    task automatic rd_lit(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        #5 chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, literal zeros.
        rd_lit(2'd0, 32'd0, "R1 ctrl reset");
        rd_lit(2'd1, 32'd0, "R1 period reset");
        rd_lit(2'd2, 32'd0, "R1 live reset");
        rd_lit(2'd3, 32'd0, "R1 total reset");
        chk("R1 irq reset", {31'd0, tick_irq}, 32'd0);

        // R2/R3/R4: core-clock counting with interrupts.
        wr(2'd1, 32'd4);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd7);
        idle(12);
        rd(2'd2, "R2 live count");
        rd(2'd0, "R4 flag after wraps");
        rd(2'd0, "R4 flag cleared by read");
        idle(9);
        rd(2'd3, "R9 cycle total");
        rd(2'd2, "R3 live after refill");

        // R5: interrupt disabled, flag still set.
        wr(2'd0, 32'd5);
        idle(12);
        rd(2'd0, "R4 flag with irq off");

        // R7: freeze and resume.
        wr(2'd0, 32'd0);
        rd(2'd2, "R7 frozen live a");
        idle(7);
        rd(2'd2, "R7 frozen live b");
        rd(2'd3, "R9 total while frozen");
        wr(2'd0, 32'd7);
        idle(3);
        rd(2'd2, "R7 resumed live");

        // R6: forced clear with arbitrary data after a wrap.
        idle(6);
        wr(2'd2, 32'hDEAD_BEEF);
        rd(2'd0, "R6 flag cleared by live write");
        rd(2'd2, "R6 live after clear");

        // R10: zero period.
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
        idle(10);
        rd(2'd2, "R10 live stays zero");
        rd(2'd0, "R10 no flag");
        rd(2'd3, "R9 total with zero period");

        // R11: unused bits ignored and read zero; total not writable.
        wr(2'd0, 32'hFFFF_FFF8);
        rd_lit(2'd0, 32'd0, "R11 ctrl unused bits");
        wr(2'd1, 32'hFFFF_FFFF);
        rd_lit(2'd1, 32'h00FF_FFFF, "R11 period upper bits");
        rd(2'd3, "R11 total before write");
        wr(2'd3, 32'h1234_5678);
        rd(2'd3, "R11 total after write");

        // R3: full-scale refill.
        wr(2'd0, 32'd5);
        idle(2);
        rd(2'd2, "R3 full scale refill");

        // R8: reference strobe source.
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd3);
        for (int i = 0; i < 10; i++) begin
            ref_tick_in = 1; idle(2);
            ref_tick_in = 0; idle(3);
            if (i % 3 == 2) rd(2'd2, "R8 strobe count");
        end
        rd(2'd0, "R8 flag from strobes");
        ref_tick_in = 1;
        idle(8);
        rd(2'd2, "R8 held strobe a");
        idle(4);
        rd(2'd2, "R8 held strobe b");
        rd(2'd3, "R9 total in strobe mode");
        ref_tick_in = 0;

        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule